// File: doc/BRIEF.md
# Mode-Filtered Performance Counter Unit

This unit holds a small bank of 32-bit event counters for a processor core. Each counter is paired with a control register. The control register chooses one event strobe out of a vector of per-cycle strobes, and it chooses the privilege modes in which that strobe is counted. Software loads a start value into the count register and enables the counter. When the top bit of the count becomes set, the unit raises an interrupt request. Software typically preloads `0x8000_0000 - N` so that the request fires after N events.

Registers are reached through a simple single-cycle port: one write strobe with its own address, and a combinational read port with its own address. A read-only configuration word reports that counters are implemented. The top bit of each control word tells software whether another counter follows, so the number of counters can be discovered at run time.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, every control and count register holds zero, `irq_o` is low, and the configuration word at address 8 reads `0x0000_0010`.
- R2: Address 2n is control register n and address 2n+1 is count register n. In a control word, bit 31 reads 1 when n is not the last counter and 0 on the last counter. Bits 30:11 read as zero. Bits 10:0 read back as written. Addresses of counters that are not implemented, and addresses 9 to 15, read zero, and writes to them change nothing.
- R3: With `exl_i` low, a counter counts only when its mode-enable bit for `mode_i` is set. The encodings are: kernel `2'b00` uses bit 1, supervisor `2'b01` uses bit 2, and user `2'b10` uses bit 3. Mode `2'b11` never counts.
- R4: With `exl_i` high, control bit 0 alone decides whether counting is allowed, and bits 3:1 are ignored.
- R5: A qualified counter adds exactly 1 on each clock edge at which `evt_i[sel]` is high, where `sel` is control bits 10:5. Strobes on other event lines have no effect on it.
- R6: Writing zero to a control register stops that counter, and its count value is kept.
- R7: `irq_o` is the OR over counters of (control bit 4 AND count bit 31). It stays high until software clears bit 31 of the count or clears the enable bit. A count that wraps from all-ones to zero drops the request.
- R8: A count write on the same edge as a qualified event stores the written value, with no increment added.
- R9: Count registers accept and return any 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Read data, combinational from `rd_addr_i` |
| evt_i | input | 64 | Per-cycle event strobes |
| mode_i | input | 2 | Current privilege mode |
| exl_i | input | 1 | Exception level active |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest states to reach are those where the count sits at the bit-31 boundary. One case is a single event that sets the top bit. Another is an all-ones count that wraps and silently drops the request. A third is a count write that lands on the same edge as a qualifying strobe. The stimulus reaches each of these in a few cycles: it preloads the count register with `0x7FFF_FFFF`, `0xFFFF_FFFF`, or some value, then aligns the write strobe and the event strobe on the same negative half-cycle. The mode filter is swept over every combination of counter, mode, exception flag and enable nibble, with the expected total worked out arithmetically.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int XLEN  = 32;
  localparam int EVT_W = 6;

  typedef enum logic [1:0] {
    MODE_KERN = 2'b00,
    MODE_SUP  = 2'b01,
    MODE_USER = 2'b10,
    MODE_RSVD = 2'b11
  } priv_mode_e;

  // packed MSB first: matches control bits 10:0
  typedef struct packed {
    logic [EVT_W-1:0] evt_sel;
    logic             irq_en;
    logic             en_user;
    logic             en_sup;
    logic             en_kern;
    logic             en_exl;
  } ctl_fields_t;

  localparam int CTL_W           = $bits(ctl_fields_t);
  localparam int CFG_PRESENT_BIT = 4;
endpackage

// File: rtl/pcu_ctl.sv
module pcu_ctl
  import pcu_pkg::*;
#(
  parameter int NUM_EVT = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  ctl_fields_t        wdata_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [1:0]         mode_i,
  input  logic               exl_i,
  output ctl_fields_t        ctl_o,
  output logic               cnt_en_o
);
  ctl_fields_t ctl_q;
  logic        mode_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (wr_i) ctl_q <= wdata_i;
  end

  always_comb begin
    if (exl_i) mode_ok = ctl_q.en_exl;
    else begin
      unique case (priv_mode_e'(mode_i))
        MODE_KERN: mode_ok = ctl_q.en_kern;
        MODE_SUP:  mode_ok = ctl_q.en_sup;
        MODE_USER: mode_ok = ctl_q.en_user;
        default:   mode_ok = 1'b0;
      endcase
    end
  end

  assign cnt_en_o = mode_ok & evt_i[ctl_q.evt_sel];
  assign ctl_o    = ctl_q;

  assert_exl_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exl_i && !ctl_q.en_exl) |-> !cnt_en_o);
  assert_rsvd_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exl_i && mode_i == 2'b11) |-> !cnt_en_o);
endmodule

// File: rtl/pcu_cnt.sv
module pcu_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  input  logic         irq_en_i,
  output logic [W-1:0] cnt_o,
  output logic         req_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_i)    cnt_q <= wdata_i;   // write beats increment
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign req_o = irq_en_i & cnt_q[W-1];

  assert_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i) |=> $stable(cnt_q));
  assert_wr_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));
  assert_wrap_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && &cnt_q) |=> !cnt_q[W-1]);
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pcu_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [XLEN-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [XLEN-1:0]     rd_data_o,
  input  logic [2**EVT_W-1:0] evt_i,
  input  logic [1:0]          mode_i,
  input  logic                exl_i,
  output logic                irq_o
);
  localparam int NUM_EVT = 2**EVT_W;
  localparam int PAD_W   = XLEN - 1 - CTL_W;
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(8);
  localparam logic [XLEN-1:0]   CFG_WORD = XLEN'(1) << CFG_PRESENT_BIT;

  logic [XLEN-1:0]    ctl_rd [NUM_CTR];
  logic [XLEN-1:0]    cnt_rd [NUM_CTR];
  logic [NUM_CTR-1:0] req;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(2*i);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(2*i+1);
    localparam logic MORE = (i < NUM_CTR-1);

    ctl_fields_t ctl;
    logic        cnt_en;
    logic        ctl_wr, cnt_wr;

    assign ctl_wr = wr_en_i && (wr_addr_i == A_CTL);
    assign cnt_wr = wr_en_i && (wr_addr_i == A_CNT);

    pcu_ctl #(.NUM_EVT(NUM_EVT)) u_ctl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (ctl_wr),
      .wdata_i (ctl_fields_t'(wr_data_i[CTL_W-1:0])),
      .evt_i   (evt_i),
      .mode_i  (mode_i),
      .exl_i   (exl_i),
      .ctl_o   (ctl),
      .cnt_en_o(cnt_en)
    );

    pcu_cnt #(.W(XLEN)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cnt_wr),
      .wdata_i (wr_data_i),
      .inc_i   (cnt_en),
      .irq_en_i(ctl.irq_en),
      .cnt_o   (cnt_rd[i]),
      .req_o   (req[i])
    );

    assign ctl_rd[i] = {MORE, {PAD_W{1'b0}}, ctl};

    assert_irq_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req[i] && !wr_en_i && !(&cnt_rd[i])) |=> req[i]);
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == CFG_ADDR) rd_data_o = CFG_WORD;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (rd_addr_i == ADDR_W'(2*k))   rd_data_o = ctl_rd[k];
      if (rd_addr_i == ADDR_W'(2*k+1)) rd_data_o = cnt_rd[k];
    end
  end

  assign irq_o = |req;

  assert_cfg_word_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == CFG_ADDR) |-> rd_data_o == 32'h0000_0010);
  assert_irq_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req == '0) |-> !irq_o);
endmodule

// File: tb/perf_counter_unit_test.sv
`timescale 1ns/1ps
module perf_counter_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [63:0] evt = '0;
  logic [1:0]  mode = 2'b00;
  logic        exl = 1'b0;
  logic        irq;
  int nvec = 0, nfail = 0;

  always #2 clk = ~clk;

  perf_counter_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .evt_i(evt), .mode_i(mode), .exl_i(exl), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic pulse(input logic [63:0] e, input int cycles);
    @(negedge clk); evt = e;
    repeat (cycles) @(negedge clk);
    evt = '0;
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int n = 0; n < 4; n++) begin
      rd(4'(2*n), d);   chk("R1 ctl reset", d, (n < 3) ? 32'h8000_0000 : 32'h0);
      rd(4'(2*n+1), d); chk("R1 cnt reset", d, 32'h0);
    end
    rd(4'd8, d); chk("R1 config", d, 32'h0000_0010);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);

    // R2 field layout and unused addresses
    for (int n = 0; n < 4; n++) begin
      wr(4'(2*n), 32'hFFFF_FFFF);
      rd(4'(2*n), d); chk("R2 ctl readback", d, (n < 3) ? 32'h8000_07FF : 32'h0000_07FF);
      wr(4'(2*n), 32'h0);
    end
    wr(4'd1, 32'h1234_5678);
    for (int a = 9; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd(4'(a), d); chk("R2 unused reads zero", d, 32'h0);
    end
    rd(4'd1, d); chk("R2 unused write no effect", d, 32'h1234_5678);
    rd(4'd8, d); chk("R2 config unchanged", d, 32'h0000_0010);

    // R9 full-width count access
    for (int n = 0; n < 4; n++) begin
      wr(4'(2*n+1), 32'hA5A5_0000 ^ (32'h1111_1111 * n));
      rd(4'(2*n+1), d); chk("R9 count rw", d, 32'hA5A5_0000 ^ (32'h1111_1111 * n));
    end

    // R3/R4/R5 sweep: counter x mode x exl x enable nibble
    for (int n = 0; n < 4; n++)
      for (int m = 0; m < 4; m++)
        for (int x = 0; x < 2; x++)
          for (int en = 0; en < 16; en++) begin
            int e; int q; logic [31:0] base;
            e = (n*7 + m*5 + x*3 + en) % 64;
            base = 32'h0010_0000 * (n+1) + 32'(en);
            if (x == 1) q = en & 1;
            else case (m)
              0: q = (en >> 1) & 1;
              1: q = (en >> 2) & 1;
              2: q = (en >> 3) & 1;
              default: q = 0;
            endcase
            wr(4'(2*n), {21'b0, 6'(e), 1'b0, 4'(en)});
            wr(4'(2*n+1), base);
            mode = 2'(m); exl = 1'(x);
            pulse(64'b1 << e, 3);
            pulse(~(64'b1 << e), 2);
            rd(4'(2*n+1), d);
            chk(x ? "R4 exl filter" : "R3 mode filter", d, base + 32'(3*q));
          end
    mode = 2'b00; exl = 1'b0;
    for (int n = 0; n < 4; n++) wr(4'(2*n), 32'h0);

    // R5 event select across counters
    for (int n = 0; n < 4; n++) begin
      wr(4'(2*n), {21'b0, 6'(10+n), 5'b00010});
      wr(4'(2*n+1), 32'h0);
    end
    pulse(64'b1 << 12, 2);
    for (int n = 0; n < 4; n++) begin
      rd(4'(2*n+1), d); chk("R5 event select", d, (n == 2) ? 32'd2 : 32'd0);
    end

    // R6 stop keeps count
    wr(4'd3, 32'd5);
    pulse(64'b1 << 11, 1);
    rd(4'd3, d); chk("R6 counts before stop", d, 32'd6);
    wr(4'd2, 32'h0);
    pulse(64'hFFFF_FFFF_FFFF_FFFF, 4);
    rd(4'd3, d); chk("R6 count held", d, 32'd6);
    rd(4'd2, d); chk("R6 ctl zero", d, 32'h8000_0000);

    // R8 write wins over increment
    @(negedge clk); evt = 64'b1 << 10; wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h55;
    @(negedge clk); wr_en = 1'b0; evt = '0;
    rd(4'd1, d); chk("R8 write wins", d, 32'h55);

    // R7 interrupt
    for (int n = 0; n < 3; n++) wr(4'(2*n), 32'h0);
    wr(4'd6, {21'b0, 6'd20, 5'b10010});
    wr(4'd7, 32'h7FFF_FFFF);
    chk("R7 irq low below msb", {31'b0, irq}, 32'h0);
    pulse(64'b1 << 20, 1);
    #1 chk("R7 irq on msb", {31'b0, irq}, 32'h1);
    pulse(64'b1 << 20, 3);
    #1 chk("R7 irq level held", {31'b0, irq}, 32'h1);
    wr(4'd6, {21'b0, 6'd20, 5'b00010});
    #1 chk("R7 irq off by enable", {31'b0, irq}, 32'h0);
    wr(4'd6, {21'b0, 6'd20, 5'b10010});
    #1 chk("R7 irq back on", {31'b0, irq}, 32'h1);
    wr(4'd7, 32'h0000_0100);
    #1 chk("R7 irq off by count write", {31'b0, irq}, 32'h0);
    wr(4'd7, 32'hFFFF_FFFF);
    #1 chk("R7 irq at all ones", {31'b0, irq}, 32'h1);
    pulse(64'b1 << 20, 1);
    #1 chk("R7 wrap drops irq", {31'b0, irq}, 32'h0);
    rd(4'd7, d); chk("R7 wrap count", d, 32'h0);
    wr(4'd0, {21'b0, 6'd1, 5'b00010});
    wr(4'd1, 32'h8000_0000);
    #1 chk("R7 msb without enable", {31'b0, irq}, 32'h0);
    wr(4'd0, {21'b0, 6'd1, 5'b10010});
    #1 chk("R7 or across counters", {31'b0, irq}, 32'h1);

    report();
  end
endmodule